// File: doc/BRIEF.md
# Dual-Mode Serial Transmitter

This block sends bytes from a processor out over a single serial line. The processor writes a byte into a holding register. As soon as the internal shift register is free, that byte is copied into it and shifted out least significant bit first. A new byte can be written while the previous one is still on the line. It then follows with no gap, so a stream of bytes leaves back to back.

A mode register picks the framing. In asynchronous mode each character is a low start bit, seven or eight data bits and a high stop bit. In clocked synchronous mode eight data bits go out alongside a transmit clock. That clock is low in the first half of each bit, high in the second half, and idles high. The data line changes together with the falling clock edge. Two mode bits choose the bit period of a simple divider. Four further mode bits are kept as plain storage.

A reset or a low-power stop request returns both registers and the shifter to their idle values.

Top module: `sertx_top`

## Requirements
- R1: After reset or a one-cycle stop request, the following hold: holding register reads 0xFF, mode register reads 0x00, txd=1, sck=1 and tx_empty=1. Any character in progress is abandoned.
- R2: rdata shows the holding register when addr=0 and the mode register when addr=1, combinationally, at any time including mid-character.
- R3: A write with addr=0 stores wdata and drives tx_empty low from the next cycle. When the shifter is free, the next clock edge copies the byte into the shifter and sets tx_empty high again. The first serial bit appears from that edge on.
- R4: Asynchronous mode (mode bit 7 = 0, bit 6 = 0) sends one low start bit, then data bits 0 to 7 in that order, then one high stop bit. Each bit lasts one bit period. txd idles high.
- R5: With mode bit 6 = 1 in asynchronous mode, the character carries only data bits 0 to 6, giving a 9-bit frame. Holding-register bit 7 is never sent.
- R6: In synchronous mode (mode bit 7 = 1), exactly 8 data bits are sent LSB first with no start or stop bit, whatever bit 6 holds. sck is low for the first half of each bit period and high for the second half, and idles high. In asynchronous mode sck stays high.
- R7: If a byte is pending when the last bit of a character ends, the next character's first bit starts on the very next cycle.
- R8: The bit period is BASE_DIV × 4^k clock cycles, where k is mode bits 1:0.
- R9: Mode bits 5:2 read back as written and do not change txd or sck.
- R10: Mode, character length and bit period are captured when a character starts. Writes to either register during a character do not alter that character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req | input | 1 | Low-power stop request, clears like reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | 0 = holding register, 1 = mode register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| txd | output | 1 | Serial data line |
| sck | output | 1 | Transmit clock for synchronous mode |
| tx_empty | output | 1 | High when the holding register may be rewritten |

## Verification
The bench targets the cycle where one character ends and a pending one begins. A design that reloads late would stretch the stop bit, and one that reloads early would clip the final data bit. It drives a 7-bit asynchronous character with bit 7 set, which an unmasked design would leak onto the line. It sets bit 6 in synchronous mode, where a shortened character would show. It rewrites the mode and holding registers halfway through a character, which exposes any design that reads the mode register live rather than capturing it. It also raises a stop request mid-frame, which must silence the line at once and restore both register values.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    // Mode register layout; the packed order follows bit 7 down to bit 0.
    typedef struct packed {
        logic       sync_mode;   // bit 7: 0 asynchronous, 1 clocked synchronous
        logic       short_char;  // bit 6: 7-bit characters in asynchronous mode
        logic [3:0] spare;       // bits 5:2: stored only
        logic [1:0] clk_sel;     // bits 1:0: divider select
    } mode_t;

    localparam int FRAME_W = 10;
    localparam int LEN_W   = 4;

    // Bits leave from index 0 upward; unused upper bits are idle-high fill.
    function automatic logic [FRAME_W-1:0] build_frame(input mode_t m, input logic [7:0] d);
        if (m.sync_mode)
            return {2'b11, d};
        else if (m.short_char)
            return {2'b11, d[6:0], 1'b0};
        return {1'b1, d, 1'b0};
    endfunction

    function automatic logic [LEN_W-1:0] frame_len(input mode_t m);
        if (m.sync_mode)
            return LEN_W'(8);
        else if (m.short_char)
            return LEN_W'(9);
        return LEN_W'(10);
    endfunction

endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
    parameter int BASE_DIV = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       restart,
    input  logic       run,
    input  logic [1:0] sel,
    output logic       bit_end,
    output logic       low_phase
);
    localparam int MAX_P = BASE_DIV * 64;
    localparam int PW    = $clog2(MAX_P) + 1;

    logic [PW-1:0] period;
    logic [PW-1:0] cnt_q;

    always_comb begin
        period    = PW'(BASE_DIV) << {sel, 1'b0};
        bit_end   = run && (cnt_q == period - PW'(1));
        low_phase = cnt_q < (period >> 1);
    end

    always_ff @(posedge clk) begin
        if (clr || restart)
            cnt_q <= '0;
        else if (run)
            cnt_q <= (cnt_q == period - PW'(1)) ? '0 : cnt_q + PW'(1);
    end

    p_cnt_in_range_r8: assert property (@(posedge clk) disable iff (rst)
        run |-> cnt_q < period);
    p_wrap_to_zero_r8: assert property (@(posedge clk) disable iff (rst)
        bit_end |=> cnt_q == '0);

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       pending,
    input  logic [7:0] din,
    input  mode_t      mode_in,
    input  logic       bit_end,
    input  logic       low_phase,
    output logic       take,
    output logic       busy,
    output logic [1:0] sel,
    output logic       txd,
    output logic       sck
);
    logic               busy_q;
    logic [FRAME_W-1:0] sh_q;
    logic [LEN_W-1:0]   left_q;
    mode_t              mode_q;
    logic               last_end;

    always_comb begin
        last_end = busy_q && bit_end && (left_q == LEN_W'(1));
        take     = pending && (!busy_q || last_end);
        busy     = busy_q;
        sel      = mode_q.clk_sel;
        txd      = busy_q ? sh_q[0] : 1'b1;
        sck      = (busy_q && mode_q.sync_mode && low_phase) ? 1'b0 : 1'b1;
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            busy_q <= 1'b0;
            sh_q   <= '1;
            left_q <= '0;
            mode_q <= '0;
        end else if (take) begin
            busy_q <= 1'b1;
            sh_q   <= build_frame(mode_in, din);
            left_q <= frame_len(mode_in);
            mode_q <= mode_in;
        end else if (busy_q && bit_end) begin
            sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
            left_q <= left_q - LEN_W'(1);
            if (left_q == LEN_W'(1))
                busy_q <= 1'b0;
        end
    end

    p_start_bit_low_r4: assert property (@(posedge clk) disable iff (clr || rst)
        take && !mode_in.sync_mode |=> !txd);
    p_sync_clock_low_r6: assert property (@(posedge clk) disable iff (clr || rst)
        take && mode_in.sync_mode |=> !sck);
    p_mode_held_r10: assert property (@(posedge clk) disable iff (clr || rst)
        busy_q && !take |=> $stable(mode_q));

endmodule

// File: rtl/sertx_regs.sv
module sertx_regs
    import sertx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       wr_en,
    input  logic       addr,
    input  logic [7:0] wdata,
    input  logic       take,
    output logic [7:0] hold,
    output mode_t      mode,
    output logic       empty
);
    logic [7:0] hold_q;
    mode_t      mode_q;
    logic       empty_q;
    logic       wr_hold;
    logic       wr_mode;

    always_comb begin
        wr_hold = wr_en && !addr;
        wr_mode = wr_en && addr;
        hold    = hold_q;
        mode    = mode_q;
        empty   = empty_q;
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            hold_q  <= 8'hFF;
            mode_q  <= '0;
            empty_q <= 1'b1;
        end else begin
            if (wr_hold)
                hold_q <= wdata;
            if (wr_mode)
                mode_q <= wdata;
            if (wr_hold)
                empty_q <= 1'b0;
            else if (take)
                empty_q <= 1'b1;
        end
    end

    p_write_clears_empty_r3: assert property (@(posedge clk) disable iff (clr || rst)
        wr_hold |=> !empty_q);
    p_take_sets_empty_r3: assert property (@(posedge clk) disable iff (clr || rst)
        take && !wr_hold |=> empty_q);
    p_hold_kept_r10: assert property (@(posedge clk) disable iff (clr || rst)
        !wr_hold |=> $stable(hold_q));

endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter int BASE_DIV = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       stop_req,
    input  logic       wr_en,
    input  logic       addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       txd,
    output logic       sck,
    output logic       tx_empty
);
    logic       clr;
    logic [7:0] hold;
    mode_t      mode;
    logic       take;
    logic       busy;
    logic [1:0] sel;
    logic       bit_end;
    logic       low_phase;

    assign clr = rst || stop_req;

    sertx_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .take  (take),
        .hold  (hold),
        .mode  (mode),
        .empty (tx_empty)
    );

    sertx_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .pending   (!tx_empty),
        .din       (hold),
        .mode_in   (mode),
        .bit_end   (bit_end),
        .low_phase (low_phase),
        .take      (take),
        .busy      (busy),
        .sel       (sel),
        .txd       (txd),
        .sck       (sck)
    );

    sertx_baud #(.BASE_DIV(BASE_DIV)) u_baud (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .restart   (take),
        .run       (busy),
        .sel       (sel),
        .bit_end   (bit_end),
        .low_phase (low_phase)
    );

    assign rdata = addr ? mode : hold;

    p_stop_restores_r1: assert property (@(posedge clk) disable iff (rst)
        stop_req |=> hold == 8'hFF && mode == '0 && tx_empty && txd && sck);

endmodule

// File: tb/tb_sertx_top.sv
`timescale 1ns/1ps
module tb_sertx_top;
    localparam int BD = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       stop_req = 1'b0;
    logic       wr_en = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       txd, sck, tx_empty;

    sertx_top #(.BASE_DIV(BD)) dut (
        .clk(clk), .rst(rst), .stop_req(stop_req), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .txd(txd), .sck(sck), .tx_empty(tx_empty)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_req = "R1";

    // Behavioural reference state
    logic [7:0] m_hold, m_mode;
    bit  m_empty, m_busy, m_sync;
    int  m_bits[10];
    int  m_n, m_idx, m_cyc, m_p;

    always @(posedge clk) begin
        bit take, last;
        cycles++;
        if (rst || stop_req) begin
            m_hold = 8'hFF; m_mode = 8'h00; m_empty = 1; m_busy = 0;
            m_sync = 0; m_idx = 0; m_cyc = 0; m_p = BD; m_n = 0;
        end else begin
            last = m_busy && (m_cyc == m_p - 1) && (m_idx == m_n - 1);
            take = !m_empty && (!m_busy || last);
            if (m_busy) begin
                if (m_cyc == m_p - 1) begin
                    m_cyc = 0;
                    m_idx++;
                    if (m_idx == m_n) m_busy = 0;
                end else m_cyc++;
            end
            if (take) begin
                m_sync = m_mode[7];
                m_p = BD * (4 ** m_mode[1:0]);
                if (m_sync) begin
                    m_n = 8;
                    for (int i = 0; i < 8; i++) m_bits[i] = m_hold[i];
                end else begin
                    m_n = m_mode[6] ? 9 : 10;
                    m_bits[0] = 0;
                    for (int i = 0; i < m_n - 2; i++) m_bits[i+1] = m_hold[i];
                    m_bits[m_n-1] = 1;
                end
                m_busy = 1; m_idx = 0; m_cyc = 0; m_empty = 1;
            end
            if (wr_en && !addr) begin m_hold = wdata; m_empty = 0; end
            if (wr_en && addr) m_mode = wdata;
        end
    end

    task automatic chk(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got %0h expected %0h at cycle %0d", tag, what, got, exp, cycles);
        end
    endtask

    // Compare every cycle, late in the low phase
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            int e_txd, e_sck;
            e_txd = m_busy ? m_bits[m_idx] : 1;
            e_sck = (m_busy && m_sync && (m_cyc < m_p / 2)) ? 0 : 1;
            chk(cur_req, "txd", txd, e_txd);
            chk(cur_req, "sck", sck, e_sck);
            chk(cur_req, "tx_empty", tx_empty, m_empty);
            chk("R2", "rdata", rdata, addr ? m_mode : m_hold);
        end
    end

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000 && !(m_empty && !m_busy); i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_empty();
        for (int i = 0; i < 20000 && !m_empty; i++) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] mode, input logic [7:0] d);
        wr(1'b1, mode);
        wr(1'b0, d);
        wait_idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        chk("R1", "reset txd", txd, 1);
        chk("R1", "reset sck", sck, 1);
        chk("R1", "reset tx_empty", tx_empty, 1);
        addr = 1'b0; #0.5;
        chk("R1", "reset holding", rdata, 8'hFF);
        addr = 1'b1; #0.5;
        chk("R1", "reset mode", rdata, 8'h00);

        // R3 and R4: plain 8-bit asynchronous characters
        cur_req = "R4";
        wr(1'b1, 8'h00);
        wr(1'b0, 8'hA5);
        #1; chk("R3", "tx_empty after write", tx_empty, 0);
        @(negedge clk); #1;
        chk("R3", "start bit after copy", txd, 0);
        chk("R3", "tx_empty after copy", tx_empty, 1);
        wait_idle();
        send(8'h00, 8'h5A);

        // R8: divider selects
        cur_req = "R8";
        send(8'h01, 8'h3C);
        send(8'h02, 8'hC3);
        send(8'h03, 8'h81);

        // R5: 7-bit characters drop bit 7
        cur_req = "R5";
        send(8'h40, 8'hFF);
        send(8'h41, 8'h80);

        // R6: synchronous, bit 6 set and clear
        cur_req = "R6";
        send(8'hC1, 8'h96);
        send(8'h80, 8'h5A);
        send(8'hC0, 8'h01);

        // R7: back-to-back in both modes
        cur_req = "R7";
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h11); wait_empty();
        wr(1'b0, 8'h22); wait_empty();
        wr(1'b0, 8'h33); wait_idle();
        wr(1'b1, 8'h81);
        wr(1'b0, 8'hE7); wait_empty();
        wr(1'b0, 8'h18); wait_idle();

        // R10: register writes during a character
        cur_req = "R10";
        wr(1'b1, 8'h01);
        wr(1'b0, 8'h0F);
        repeat (12) @(negedge clk);
        wr(1'b1, 8'h80);
        wr(1'b0, 8'hF0);
        wait_idle();

        // R9: spare mode bits stored but inert
        cur_req = "R9";
        send(8'h3C, 8'h6B);
        addr = 1'b1; #0.5;
        chk("R9", "spare bits readback", rdata, 8'h3C);

        // R1: stop request mid-character
        cur_req = "R1";
        wr(1'b1, 8'h01);
        wr(1'b0, 8'h00);
        repeat (10) @(negedge clk);
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        #1;
        chk("R1", "stop txd", txd, 1);
        chk("R1", "stop tx_empty", tx_empty, 1);
        addr = 1'b0; #0.5;
        chk("R1", "stop holding", rdata, 8'hFF);
        addr = 1'b1; #0.5;
        chk("R1", "stop mode", rdata, 8'h00);
        repeat (5) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule